// File: doc/BRIEF.md
# Priority-Stacked Layer Compositor

This block builds one output pixel per clock from a background colour and three layers: two graphic planes and one video plane. A raster position (x, y) comes in with the pixel each layer has already fetched for that position. The block decides which layers cover the position, orders them by programmed priority and blends them from the bottom up over the background. The composited 24-bit pixel comes out two clocks later.

Configuration arrives on plain input ports and is copied into an active set only when the commit strobe is high. The commit is meant to be pulsed once per frame, for example in vertical blanking. Graphic layers take one of four packed pixel formats and carry premultiplied per-pixel alpha. The video layer is always opaque. Colour conversion is not done here: all layers and the background are assumed to share one three-channel space, with the channel that sits in bits [23:16] of the output first.

Top module: `pix_compositor`

## Requirements
- R1: During reset and after it, before any commit, the active background is 0x008080 (first channel 0 in [23:16], 128 in [15:8] and in [7:0]), every layer is disabled and `out_valid_o` is low.
- R2: When `cfg_commit_i` is high at a clock edge, all `cfg_*` ports become the active configuration for pixels presented at later edges. Changes on `cfg_*` ports without a commit have no effect on the output.
- R3: A pixel presented with `pix_valid_i` high at edge k appears on `out_pix_o` with `out_valid_o` high after edge k+2. While `out_valid_o` is low, `out_pix_o` keeps its last value, which is 0 after reset.
- R4: When no layer contributes at a position, the output equals the active background colour.
- R5: Layer i contributes only when its enable bit `cfg_en_i[i]` is set and dx ≤ x < dx + width' and dy ≤ y < dy + height', where width' and height' are the programmed width and height after scaling. A zero width or height covers nothing.
- R6: For graphic layer g, `cfg_hscale_i[g]` = 1 doubles the horizontal extent and `cfg_vscale_i[g]` = 1 doubles the vertical extent. The video layer is never scaled.
- R7: The graphic format codes are 3 bits wide. Code 4 is RGB565, with red in [15:11], green in [10:5], blue in [4:0], alpha 255, and 5- or 6-bit fields widened by replicating their top bits. Code 5 is ARGB1555, with alpha in [15] expanded to 0 or 255 and 5-bit colours in [14:10], [9:5], [4:0]. Code 6 is ARGB4444, with alpha in [15:12] and colours in [11:8], [7:4], [3:0], each nibble replicated to 8 bits. Code 7 is ARGB8888, with alpha in [31:24] and colours in [23:0]. Codes 0 to 3 make the layer contribute nothing.
- R8: Each contributing graphic layer is blended per channel as out = min(255, src + round(dst × (255 − a) / 255)), where src is the layer's premultiplied colour and dst is the result of everything below it.
- R9: The video layer, `vid_pix_i`, is opaque: where it contributes it replaces everything beneath it.
- R10: Layers stack in ascending priority, so a larger priority is nearer the top. Among equal priorities the higher layer index is on top. Index 0 is graphic 0, index 1 is graphic 1 and index 2 is video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_commit_i | input | 1 | Copy all cfg_* ports into the active set |
| cfg_bg_i | input | 24 | Background colour, packed three channels |
| cfg_en_i | input | NUM_GFX+1 | Layer enable bits, one per layer index |
| cfg_prio_i | input | (NUM_GFX+1)*PRIO_W | Layer priority fields, layer i at [i*PRIO_W +: PRIO_W] |
| cfg_fmt_i | input | NUM_GFX*3 | Graphic format codes, layer g at [g*3 +: 3] |
| cfg_hscale_i | input | NUM_GFX | Horizontal doubling per graphic layer |
| cfg_vscale_i | input | NUM_GFX | Vertical doubling per graphic layer |
| cfg_x_i | input | (NUM_GFX+1)*X_W | Destination x offsets |
| cfg_y_i | input | (NUM_GFX+1)*X_W | Destination y offsets |
| cfg_w_i | input | (NUM_GFX+1)*X_W | Unscaled widths |
| cfg_h_i | input | (NUM_GFX+1)*X_W | Unscaled heights |
| pix_valid_i | input | 1 | Raster position and layer pixels are valid |
| pix_x_i | input | X_W | Raster x position |
| pix_y_i | input | X_W | Raster y position |
| gfx_pix_i | input | NUM_GFX*32 | Raw graphic pixels, layer g at [g*32 +: 32] |
| vid_pix_i | input | 24 | Video pixel |
| out_valid_o | output | 1 | Composited pixel is valid |
| out_pix_o | output | 24 | Composited pixel |

## Verification
The bench goes after the rectangle edges, where an off-by-one comparison would add or drop the last column or row, and after the doubled extents, where a design that ignored a scale bit would clip the layer to half its size. Every format is driven with varied alpha. A 1-bit or 4-bit alpha that was expanded wrongly would leave too much or too little of the layer beneath showing. A reserved format code that was decoded anyway would paint garbage. Priority swaps and ties are exercised together with overlapping translucent layers, since a design that mis-sorted the stack would blend in the wrong order and shift every channel. Uncommitted configuration changes and gaps in the valid stream are also driven: a design that let configuration bypass the commit, or that refreshed the pixel output when no valid pixel was present, would differ at once.

// File: rtl/pix_comp_pkg.sv
package pix_comp_pkg;

    localparam int CH_W  = 8;
    localparam int NUM_CH = 3;
    localparam int PIX_W = CH_W * NUM_CH;
    localparam int RAW_W = 32;
    localparam int FMT_W = 3;

    localparam logic [PIX_W-1:0] BG_RESET = 24'h008080;

    localparam logic [FMT_W-1:0] FMT_RGB565   = 3'd4;
    localparam logic [FMT_W-1:0] FMT_ARGB1555 = 3'd5;
    localparam logic [FMT_W-1:0] FMT_ARGB4444 = 3'd6;
    localparam logic [FMT_W-1:0] FMT_ARGB8888 = 3'd7;

    // premultiplied pixel: alpha plus three channels
    typedef struct packed {
        logic [CH_W-1:0]  a;
        logic [PIX_W-1:0] c;
    } px_t;

    function automatic logic [7:0] rep5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] rep6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic [7:0] rep4(input logic [3:0] v);
        return {v, v};
    endfunction

    function automatic px_t expand_gfx(input logic [RAW_W-1:0] raw,
                                       input logic [FMT_W-1:0] fmt);
        px_t p;
        case (fmt)
            FMT_RGB565: begin
                p.a = 8'hFF;
                p.c = {rep5(raw[15:11]), rep6(raw[10:5]), rep5(raw[4:0])};
            end
            FMT_ARGB1555: begin
                p.a = {8{raw[15]}};
                p.c = {rep5(raw[14:10]), rep5(raw[9:5]), rep5(raw[4:0])};
            end
            FMT_ARGB4444: begin
                p.a = rep4(raw[15:12]);
                p.c = {rep4(raw[11:8]), rep4(raw[7:4]), rep4(raw[3:0])};
            end
            FMT_ARGB8888: begin
                p.a = raw[31:24];
                p.c = raw[23:0];
            end
            default: p = '0;
        endcase
        return p;
    endfunction

    // round(v / 255) for v up to 255*255, using shifts only
    function automatic logic [7:0] div255_round(input logic [15:0] v);
        logic [16:0] t;
        t = {1'b0, v} + 17'd128;
        t = t + (t >> 8);
        return t[15:8];
    endfunction

    function automatic logic [7:0] blend_ch(input logic [7:0] src,
                                            input logic [7:0] dst,
                                            input logic [7:0] a);
        logic [15:0] prod;
        logic [8:0]  sum;
        prod = 16'(dst) * 16'(8'hFF - a);
        sum  = {1'b0, src} + {1'b0, div255_round(prod)};
        return sum[8] ? 8'hFF : sum[7:0];
    endfunction

endpackage

// File: rtl/pix_comp_rect_hit.sv
module pix_comp_rect_hit #(
    parameter int X_W = 12
) (
    input  logic [X_W-1:0] x_i,
    input  logic [X_W-1:0] y_i,
    input  logic [X_W-1:0] dx_i,
    input  logic [X_W-1:0] dy_i,
    input  logic [X_W-1:0] w_i,
    input  logic [X_W-1:0] h_i,
    input  logic           hscale_i,
    input  logic           vscale_i,
    output logic           hit_o
);
    localparam int E_W = X_W + 2;

    logic [E_W-1:0] ext_w, ext_h, right, bottom;

    always_comb begin
        ext_w  = hscale_i ? {1'b0, w_i, 1'b0} : {2'b00, w_i};
        ext_h  = vscale_i ? {1'b0, h_i, 1'b0} : {2'b00, h_i};
        right  = {2'b00, dx_i} + ext_w;
        bottom = {2'b00, dy_i} + ext_h;
        hit_o  = (x_i >= dx_i) && ({2'b00, x_i} < right) &&
                 (y_i >= dy_i) && ({2'b00, y_i} < bottom);
    end
endmodule

// File: rtl/pix_comp_order.sv
module pix_comp_order
    import pix_comp_pkg::*;
#(
    parameter int N      = 3,
    parameter int PRIO_W = 4
) (
    input  logic [N*PRIO_W-1:0] prio_i,
    input  px_t  [N-1:0]        px_i,
    output px_t  [N-1:0]        px_o   // slot 0 is the bottom of the stack
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int KEY_W = PRIO_W + IDX_W;

    logic [N-1:0][KEY_W-1:0] key;
    logic [N-1:0][IDX_W-1:0] rank;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            key[i] = {prio_i[i*PRIO_W +: PRIO_W], IDX_W'(i)};
        end
        for (int i = 0; i < N; i++) begin
            rank[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && key[j] < key[i]) begin
                    rank[i] = rank[i] + IDX_W'(1);
                end
            end
        end
        for (int s = 0; s < N; s++) begin
            px_o[s] = '0;
            for (int i = 0; i < N; i++) begin
                if (rank[i] == IDX_W'(s)) begin
                    px_o[s] = px_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/pix_comp_blend.sv
module pix_comp_blend
    import pix_comp_pkg::*;
(
    input  px_t              src_i,
    input  logic [PIX_W-1:0] dst_i,
    output logic [PIX_W-1:0] out_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign out_o[c*CH_W +: CH_W] = blend_ch(src_i.c[c*CH_W +: CH_W],
                                                dst_i[c*CH_W +: CH_W],
                                                src_i.a);
    end
endmodule

// File: rtl/pix_compositor.sv
module pix_compositor
    import pix_comp_pkg::*;
#(
    parameter int NUM_GFX = 2,
    parameter int X_W     = 12,
    parameter int PRIO_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_commit_i,
    input  logic [23:0]                      cfg_bg_i,
    input  logic [NUM_GFX:0]                 cfg_en_i,
    input  logic [(NUM_GFX+1)*PRIO_W-1:0]    cfg_prio_i,
    input  logic [NUM_GFX*3-1:0]             cfg_fmt_i,
    input  logic [NUM_GFX-1:0]               cfg_hscale_i,
    input  logic [NUM_GFX-1:0]               cfg_vscale_i,
    input  logic [(NUM_GFX+1)*X_W-1:0]       cfg_x_i,
    input  logic [(NUM_GFX+1)*X_W-1:0]       cfg_y_i,
    input  logic [(NUM_GFX+1)*X_W-1:0]       cfg_w_i,
    input  logic [(NUM_GFX+1)*X_W-1:0]       cfg_h_i,
    input  logic                             pix_valid_i,
    input  logic [X_W-1:0]                   pix_x_i,
    input  logic [X_W-1:0]                   pix_y_i,
    input  logic [NUM_GFX*32-1:0]            gfx_pix_i,
    input  logic [23:0]                      vid_pix_i,
    output logic                             out_valid_o,
    output logic [23:0]                      out_pix_o
);
    localparam int NUM_LAYERS = NUM_GFX + 1;
    localparam int GEO_W      = NUM_LAYERS * X_W;

    // active (committed) configuration
    logic [PIX_W-1:0]             act_bg;
    logic [NUM_LAYERS-1:0]        act_en;
    logic [NUM_LAYERS*PRIO_W-1:0] act_prio;
    logic [NUM_GFX*FMT_W-1:0]     act_fmt;
    logic [NUM_GFX-1:0]           act_hs, act_vs;
    logic [GEO_W-1:0]             act_x, act_y, act_w, act_h;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_bg   <= BG_RESET;
            act_en   <= '0;
            act_prio <= '0;
            act_fmt  <= '0;
            act_hs   <= '0;
            act_vs   <= '0;
            act_x    <= '0;
            act_y    <= '0;
            act_w    <= '0;
            act_h    <= '0;
        end else if (cfg_commit_i) begin
            act_bg   <= cfg_bg_i;
            act_en   <= cfg_en_i;
            act_prio <= cfg_prio_i;
            act_fmt  <= cfg_fmt_i;
            act_hs   <= cfg_hscale_i;
            act_vs   <= cfg_vscale_i;
            act_x    <= cfg_x_i;
            act_y    <= cfg_y_i;
            act_w    <= cfg_w_i;
            act_h    <= cfg_h_i;
        end
    end

    // per-layer decode and coverage
    px_t [NUM_LAYERS-1:0]  lay_px;
    logic [NUM_LAYERS-1:0] lay_hit;

    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
        logic hs, vs;
        px_t  px;
        if (i < NUM_GFX) begin : g_gfx
            assign hs = act_hs[i];
            assign vs = act_vs[i];
            assign px = expand_gfx(gfx_pix_i[i*RAW_W +: RAW_W],
                                   act_fmt[i*FMT_W +: FMT_W]);
        end else begin : g_vid
            assign hs = 1'b0;
            assign vs = 1'b0;
            assign px = '{a: 8'hFF, c: vid_pix_i};
        end

        pix_comp_rect_hit #(.X_W(X_W)) u_hit (
            .x_i      (pix_x_i),
            .y_i      (pix_y_i),
            .dx_i     (act_x[i*X_W +: X_W]),
            .dy_i     (act_y[i*X_W +: X_W]),
            .w_i      (act_w[i*X_W +: X_W]),
            .h_i      (act_h[i*X_W +: X_W]),
            .hscale_i (hs),
            .vscale_i (vs),
            .hit_o    (lay_hit[i])
        );

        // a non-contributing layer becomes fully transparent
        assign lay_px[i] = (act_en[i] && lay_hit[i]) ? px : '0;
    end

    px_t [NUM_LAYERS-1:0] sorted_px;

    pix_comp_order #(.N(NUM_LAYERS), .PRIO_W(PRIO_W)) u_order (
        .prio_i (act_prio),
        .px_i   (lay_px),
        .px_o   (sorted_px)
    );

    // stage 1: sorted layers and background
    logic                 s1_valid;
    logic [PIX_W-1:0]     s1_bg;
    px_t [NUM_LAYERS-1:0] s1_px;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_bg    <= BG_RESET;
            s1_px    <= '0;
        end else begin
            s1_valid <= pix_valid_i;
            s1_bg    <= act_bg;
            s1_px    <= sorted_px;
        end
    end

    // stage 2: bottom-up blend chain
    logic [NUM_LAYERS:0][PIX_W-1:0] chain;
    assign chain[0] = s1_bg;

    for (genvar s = 0; s < NUM_LAYERS; s++) begin : g_blend
        pix_comp_blend u_blend (
            .src_i (s1_px[s]),
            .dst_i (chain[s]),
            .out_o (chain[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            out_pix_o   <= '0;
        end else begin
            out_valid_o <= s1_valid;
            if (s1_valid) begin
                out_pix_o <= chain[NUM_LAYERS];
            end
        end
    end
endmodule

// File: rtl/pix_compositor_chk.sv
module pix_compositor_chk #(
    parameter int NUM_LAYERS = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_commit_i,
    input logic [23:0]           cfg_bg_i,
    input logic [NUM_LAYERS-1:0] cfg_en_i,
    input logic                  pix_valid_i,
    input logic                  out_valid_o,
    input logic [23:0]           out_pix_o,
    input logic [23:0]           act_bg,
    input logic [NUM_LAYERS-1:0] act_en
);
    // R1: reset restores background and clears enables and output valid
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (act_bg == 24'h008080 && act_en == '0 && !out_valid_o));

    // R2: commit copies configuration ports into the active set
    a_r2_commit_load: assert property (@(posedge clk) disable iff (rst)
        cfg_commit_i |=> (act_bg == $past(cfg_bg_i) && act_en == $past(cfg_en_i)));

    // R3: valid emerges two clocks after it enters
    a_r3_latency_valid: assert property (@(posedge clk) disable iff (rst)
        pix_valid_i |-> ##2 out_valid_o);

    a_r3_latency_idle: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_i |-> ##2 !out_valid_o);

    // R3: output pixel holds while not valid
    a_r3_hold_pixel: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> $stable(out_pix_o));

    // R4: with every layer disabled the output is the background
    a_r4_bg_only: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && $past(act_en, 2) == '0) |-> out_pix_o == $past(act_bg, 2));
endmodule

bind pix_compositor pix_compositor_chk #(.NUM_LAYERS(NUM_LAYERS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_commit_i (cfg_commit_i),
    .cfg_bg_i     (cfg_bg_i),
    .cfg_en_i     (cfg_en_i),
    .pix_valid_i  (pix_valid_i),
    .out_valid_o  (out_valid_o),
    .out_pix_o    (out_pix_o),
    .act_bg       (act_bg),
    .act_en       (act_en)
);

// File: tb/pix_compositor_tb.sv
module pix_compositor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 2;
    localparam int XW = 12;
    localparam int PW = 4;
    localparam int NL = NG + 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_commit_i;
    logic [23:0]       cfg_bg_i;
    logic [NL-1:0]     cfg_en_i;
    logic [NL*PW-1:0]  cfg_prio_i;
    logic [NG*3-1:0]   cfg_fmt_i;
    logic [NG-1:0]     cfg_hscale_i, cfg_vscale_i;
    logic [NL*XW-1:0]  cfg_x_i, cfg_y_i, cfg_w_i, cfg_h_i;
    logic              pix_valid_i;
    logic [XW-1:0]     pix_x_i, pix_y_i;
    logic [NG*32-1:0]  gfx_pix_i;
    logic [23:0]       vid_pix_i;
    logic              out_valid_o;
    logic [23:0]       out_pix_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_compositor #(.NUM_GFX(NG), .X_W(XW), .PRIO_W(PW)) dut_i (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_req = "R1";

    // reference state
    int a_bg, a_en[NL], a_prio[NL], a_fmt[NG], a_hs[NG], a_vs[NG];
    int a_x[NL], a_y[NL], a_w[NL], a_h[NL];
    bit dl0v, dl1v;
    int dl0, dl1, held;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic reset_model();
        a_bg = 'h008080;
        for (int i = 0; i < NL; i++) begin
            a_en[i] = 0; a_prio[i] = 0; a_x[i] = 0; a_y[i] = 0; a_w[i] = 0; a_h[i] = 0;
        end
        for (int g = 0; g < NG; g++) begin
            a_fmt[g] = 0; a_hs[g] = 0; a_vs[g] = 0;
        end
    endtask

    task automatic load_model();
        a_bg = int'(cfg_bg_i);
        for (int i = 0; i < NL; i++) begin
            a_en[i]   = int'(cfg_en_i[i]);
            a_prio[i] = int'(cfg_prio_i[i*PW +: PW]);
            a_x[i]    = int'(cfg_x_i[i*XW +: XW]);
            a_y[i]    = int'(cfg_y_i[i*XW +: XW]);
            a_w[i]    = int'(cfg_w_i[i*XW +: XW]);
            a_h[i]    = int'(cfg_h_i[i*XW +: XW]);
        end
        for (int g = 0; g < NG; g++) begin
            a_fmt[g] = int'(cfg_fmt_i[g*3 +: 3]);
            a_hs[g]  = int'(cfg_hscale_i[g]);
            a_vs[g]  = int'(cfg_vscale_i[g]);
        end
    endtask

    function automatic int r5(int v); return (v << 3) | (v >> 2); endfunction
    function automatic int r6(int v); return (v << 2) | (v >> 4); endfunction

    function automatic int model(int x, int y);
        int la[NL];
        int lc[NL][3];
        bit ok[NL];
        int d[3];
        for (int i = 0; i < NL; i++) begin
            int ew, eh;
            bit fv;
            ew = a_w[i] * ((i < NG && a_hs[i] != 0) ? 2 : 1);
            eh = a_h[i] * ((i < NG && a_vs[i] != 0) ? 2 : 1);
            fv = 1'b1;
            if (i == NG) begin
                la[i] = 255;
                for (int c = 0; c < 3; c++) lc[i][c] = int'(vid_pix_i >> (16 - 8*c)) & 255;
            end else begin
                int p;
                p = int'(gfx_pix_i[i*32 +: 32]);
                case (a_fmt[i])
                    4: begin la[i] = 255; lc[i][0] = r5((p >> 11) & 31);
                             lc[i][1] = r6((p >> 5) & 63); lc[i][2] = r5(p & 31); end
                    5: begin la[i] = ((p >> 15) & 1) * 255; lc[i][0] = r5((p >> 10) & 31);
                             lc[i][1] = r5((p >> 5) & 31); lc[i][2] = r5(p & 31); end
                    6: begin la[i] = ((p >> 12) & 15) * 17; lc[i][0] = ((p >> 8) & 15) * 17;
                             lc[i][1] = ((p >> 4) & 15) * 17; lc[i][2] = (p & 15) * 17; end
                    7: begin la[i] = (p >> 24) & 255; lc[i][0] = (p >> 16) & 255;
                             lc[i][1] = (p >> 8) & 255; lc[i][2] = p & 255; end
                    default: begin fv = 1'b0; la[i] = 0;
                             lc[i][0] = 0; lc[i][1] = 0; lc[i][2] = 0; end
                endcase
            end
            ok[i] = (a_en[i] != 0) && fv && x >= a_x[i] && x < a_x[i] + ew &&
                    y >= a_y[i] && y < a_y[i] + eh;
        end
        for (int c = 0; c < 3; c++) d[c] = (a_bg >> (16 - 8*c)) & 255;
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < NL; i++) begin
                if (ok[i] && a_prio[i] * 4 + i == k) begin
                    for (int c = 0; c < 3; c++) begin
                        int s;
                        s = lc[i][c] + (d[c] * (255 - la[i]) + 127) / 255;
                        d[c] = (s > 255) ? 255 : s;
                    end
                end
            end
        end
        return (d[0] << 16) | (d[1] << 8) | d[2];
    endfunction

    // one clock: predict for current inputs, advance, compare at negedge
    task automatic cycle();
        bit ev;
        int e;
        ev = pix_valid_i && !rst;
        e  = ev ? model(int'(pix_x_i), int'(pix_y_i)) : 0;
        if (rst) reset_model();
        else if (cfg_commit_i) load_model();
        @(posedge clk);
        dl1v = dl0v; dl1 = dl0; dl0v = ev; dl0 = e;
        if (rst) begin dl0v = 0; dl1v = 0; held = 0; end
        @(negedge clk);
        if (!rst) begin
            check(out_valid_o == dl1v, {cur_req, " valid"}, int'(out_valid_o), int'(dl1v));
            if (dl1v) begin
                check(int'(out_pix_o) == dl1, cur_req, int'(out_pix_o), dl1);
                held = dl1;
            end else begin
                check(int'(out_pix_o) == held, {cur_req, " R3 hold"}, int'(out_pix_o), held);
            end
        end
    endtask

    task automatic px(input int x, input int y);
        pix_valid_i = 1'b1;
        pix_x_i = XW'(x);
        pix_y_i = XW'(y);
        gfx_pix_i = {$urandom, $urandom};
        vid_pix_i = 24'($urandom);
        cycle();
        pix_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        pix_valid_i = 1'b0;
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic scan(input int x0, input int x1, input int y0, input int y1);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++) px(x, y);
        idle(2);
    endtask

    task automatic commit();
        cfg_commit_i = 1'b1;
        cycle();
        cfg_commit_i = 1'b0;
    endtask

    task automatic set_geo(input int i, input int x, input int y, input int w, input int h);
        cfg_x_i[i*XW +: XW] = XW'(x);
        cfg_y_i[i*XW +: XW] = XW'(y);
        cfg_w_i[i*XW +: XW] = XW'(w);
        cfg_h_i[i*XW +: XW] = XW'(h);
    endtask

    task automatic set_prio(input int i, input int p);
        cfg_prio_i[i*PW +: PW] = PW'(p);
    endtask

    initial begin
        void'($urandom(7));
        rst = 1'b1; cfg_commit_i = 0; cfg_bg_i = 0; cfg_en_i = 0; cfg_prio_i = 0;
        cfg_fmt_i = 0; cfg_hscale_i = 0; cfg_vscale_i = 0;
        cfg_x_i = 0; cfg_y_i = 0; cfg_w_i = 0; cfg_h_i = 0;
        pix_valid_i = 0; pix_x_i = 0; pix_y_i = 0; gfx_pix_i = 0; vid_pix_i = 0;
        dl0v = 0; dl1v = 0; dl0 = 0; dl1 = 0; held = 0;
        reset_model();
        @(negedge clk);
        pix_valid_i = 1'b1;
        cycle(); cycle(); cycle();
        // R1: outputs during reset
        check(out_valid_o == 1'b0, "R1 reset valid", int'(out_valid_o), 0);
        check(out_pix_o == 24'h0, "R1 reset pixel", int'(out_pix_o), 0);
        pix_valid_i = 1'b0;
        rst = 1'b0;
        idle(1);
        cur_req = "R1";
        px(3, 3); idle(2);
        check(out_pix_o == 24'h008080, "R1 reset background", int'(out_pix_o), 'h008080);

        // R2: commit, then uncommitted changes ignored
        cur_req = "R2";
        cfg_bg_i = 24'h123456; commit(); scan(0, 2, 0, 0);
        cfg_bg_i = 24'hABCDEF; cfg_en_i = '1; set_geo(0, 0, 0, 100, 100);
        set_geo(2, 0, 0, 100, 100); cfg_fmt_i = 6'o77;
        scan(0, 3, 0, 1);
        check(out_pix_o == 24'h123456, "R2 ignored without commit", int'(out_pix_o), 'h123456);

        // R4: enabled layer outside the position
        cur_req = "R4";
        cfg_en_i = 3'b001; set_geo(0, 200, 200, 4, 4); set_geo(2, 0, 0, 0, 0);
        commit(); scan(0, 3, 0, 1);

        // R5: rectangle edges
        cur_req = "R5";
        set_geo(0, 10, 5, 4, 3); set_prio(0, 1); commit(); scan(8, 15, 4, 8);
        set_geo(0, 10, 5, 0, 3); commit(); scan(9, 11, 5, 5);

        // R6: doubled extents
        cur_req = "R6";
        set_geo(0, 10, 5, 4, 3); cfg_hscale_i = 2'b01; cfg_vscale_i = 2'b01;
        commit(); scan(8, 19, 4, 12);
        cfg_hscale_i = 2'b01; cfg_vscale_i = 2'b00; commit(); scan(16, 19, 7, 8);
        cfg_hscale_i = 0; cfg_vscale_i = 0;

        // R7: each format code, including a reserved one
        cur_req = "R7";
        set_geo(0, 0, 0, 8, 2);
        for (int f = 2; f <= 7; f++) begin
            cfg_fmt_i[2:0] = 3'(f); commit(); scan(0, 7, 0, 1);
        end

        // R8 / R10: overlapping translucent graphic layers
        cur_req = "R8";
        cfg_en_i = 3'b011; cfg_fmt_i = {3'd7, 3'd6};
        set_geo(0, 0, 0, 6, 3); set_geo(1, 3, 1, 6, 3);
        set_prio(0, 1); set_prio(1, 2); commit(); scan(0, 9, 0, 4);
        cur_req = "R10";
        set_prio(0, 2); set_prio(1, 1); commit(); scan(2, 7, 1, 3);
        set_prio(0, 3); set_prio(1, 3); commit(); scan(2, 7, 1, 3);

        // R9: opaque video in the middle, then on top
        cur_req = "R9";
        cfg_en_i = 3'b111; cfg_fmt_i = {3'd7, 3'd5};
        set_geo(2, 1, 0, 6, 4); set_prio(0, 1); set_prio(2, 2); set_prio(1, 3);
        commit(); scan(0, 9, 0, 4);
        set_prio(2, 4); commit(); scan(0, 9, 0, 4);
        set_prio(2, 3); set_prio(1, 3); commit(); scan(2, 7, 1, 3);

        // R3: valid gaps
        cur_req = "R3";
        for (int k = 0; k < 12; k++) begin
            px(k, 1);
            idle(k % 3);
        end
        idle(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule